// File: doc/BRIEF.md
# Receive Byte Ring with Ready Event

This block is the receive half of a serial port's register-facing logic. Deserialized bytes arrive one per cycle from an upstream source and are appended to a small circular store. The processor side drains the store through read strobes on a receive data register. The head byte is always visible on an output, whether or not anything is queued.

The block also reports how many slots are free, so that the upstream source can throttle itself. While receive is disarmed it reports no free space at all. A sticky ready event goes high when a byte lands. It goes high again after a pop that leaves bytes behind, and it feeds the interrupt logic. Software clears the event by writing zero to its register. Any nonzero write leaves it alone.

Top module: `rx_ready_buffer`

## Requirements
- R1: `head_byte` always presents the stored entry at the head position. This holds when the ring is empty and when receive is disarmed.
- R2: A read strobe removes the head entry only when `rx_armed` is 1 and the ring holds at least one byte. The head index then steps by one and wraps from DEPTH-1 to 0, and the count drops by one. Any other read strobe changes neither the index nor the count.
- R3: `free_slots` equals DEPTH minus the count while `rx_armed` is 1, and equals 0 while `rx_armed` is 0.
- R4: An accepted incoming byte is stored at index (head + count) modulo DEPTH, so bytes leave in arrival order. Every accepted byte sets the ready event in the next cycle.
- R5: An incoming byte that arrives while the count equals DEPTH at the start of the cycle is discarded. The count and the stored bytes stay as they were, and the byte does not set the ready event.
- R6: After a pop, the ready event is set if the resulting count is nonzero. A pop that leaves the ring empty does not change the event by itself.
- R7: A write to the ready-event register with data equal to 0 clears the event. A write with any nonzero data has no effect on it.
- R8: After reset the head index and the count are 0, the ready event is 0 and every stored entry is 0. As a result `head_byte` reads 0 and `free_slots` reads DEPTH when armed.
- R9: When a byte is accepted and a pop occurs in the same cycle, both take effect and the count is unchanged.
- R10: When a setting condition (R4 or R6) and a zero write (R7) fall in the same cycle, the event ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_armed | input | 1 | Receive is started |
| in_valid | input | 1 | Incoming byte present this cycle |
| in_byte | input | 8 | Incoming byte |
| data_rd | input | 1 | Read strobe of the receive data register |
| rdy_wr | input | 1 | Write strobe of the ready-event register |
| rdy_wdata | input | WDATA_W | Write data for the ready-event register |
| head_byte | output | 8 | Byte at the head position |
| free_slots | output | $clog2(DEPTH+1) | Free space offered upstream |
| rdy_event | output | 1 | Sticky receive-ready event |

## Verification
A reference ring in the bench follows the requirements and is compared against the block every cycle. It is driven first by a structured sweep and then by a long pseudo-random run. The sweep starts at each fill level from empty to full and applies all 32 combinations of armed, arrival, read strobe, write strobe and zero/nonzero write data. This separates the full-ring discard from the single-slot-left acceptance, and the armed pop from the disarmed read. It also separates a pop that leaves bytes behind from one that empties the ring, and a zero write from a nonzero one. Directed sequences then push the head index past the wrap point. They also check arrival order after a refill, and check that the event stays set when it is set and cleared in the same cycle.

// File: rtl/rx_buf_pkg.sv
package rx_buf_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Controls handed from the index logic to the event flag
  typedef struct packed {
    logic push;
    logic pop;
    logic left_nz;
  } evt_ctl_t;
endpackage

// File: rtl/rxb_ptr_ctrl.sv
module rxb_ptr_ctrl
  import rx_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned PW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_armed,
  input  logic          in_valid,
  input  logic          data_rd,
  output logic [PW-1:0] head,
  output logic [CW-1:0] count,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output evt_ctl_t      evt
);
  localparam int unsigned SW      = ((PW > CW) ? PW : CW) + 1;
  localparam logic [SW-1:0] DEP_S = SW'(DEPTH);
  localparam logic [CW-1:0] DEP_C = CW'(DEPTH);
  localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);

  logic          pop, push;
  logic [PW-1:0] head_d;
  logic [CW-1:0] count_d;
  logic [SW-1:0] tail_sum;
  logic          head_en, count_en;

  always_comb begin
    pop      = data_rd && rx_armed && (count != '0);
    push     = in_valid && (count != DEP_C);
    tail_sum = SW'(head) + SW'(count);
    if (tail_sum >= DEP_S) begin
      wr_idx = PW'(tail_sum - DEP_S);
    end else begin
      wr_idx = PW'(tail_sum);
    end
    wr_en    = push;
    head_en  = pop;
    head_d   = (head == LAST) ? '0 : head + PW'(1);
    count_en = pop ^ push;
    count_d  = push ? count + CW'(1) : count - CW'(1);
    evt.push    = push;
    evt.pop     = pop;
    evt.left_nz = (count_en ? count_d : count) != '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
    end else if (head_en) begin
      head <= head_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (count_en) begin
      count <= count_d;
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEP_C);
  // R2
  disarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_armed) |=> head == $past(head));
  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == DEP_C && !data_rd) |=> count == DEP_C);
  // R9
  both_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && data_rd && rx_armed && count != '0 && count != DEP_C) |=> $stable(count));
endmodule

// File: rtl/rxb_store.sv
module rxb_store
  import rx_buf_pkg::*;
#(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  byte_t         wr_data,
  input  logic [PW-1:0] rd_idx,
  output byte_t         rd_data
);
  byte_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    always_comb slot_en = wr_en && (wr_idx == PW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else if (slot_en) begin
        slot_q[i] <= wr_data;
      end
    end

    // R4
    slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == PW'(i)) |=> slot_q[i] == $past(wr_data));
  end

  always_comb begin
    rd_data = '0;
    for (int j = 0; j < DEPTH; j++) begin
      if (rd_idx == PW'(j)) rd_data = slot_q[j];
    end
  end
endmodule

// File: rtl/rxb_ready_flag.sv
module rxb_ready_flag
  import rx_buf_pkg::*;
#(
  parameter int unsigned WDATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  evt_ctl_t           evt,
  input  logic               rdy_wr,
  input  logic [WDATA_W-1:0] rdy_wdata,
  output logic               flag
);
  logic set_req, clr_req, flag_en, flag_d;

  always_comb begin
    set_req = evt.push || (evt.pop && evt.left_nz);
    clr_req = rdy_wr && (rdy_wdata == '0);
    flag_en = set_req || clr_req;
    flag_d  = set_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flag_en) begin
      flag <= flag_d;
    end
  end

  // R4
  push_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt.push |=> flag);
  // R7
  zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_wr && rdy_wdata == '0 && !evt.push && !evt.pop) |=> !flag);
  // R7
  nonzero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.push && !evt.pop && !(rdy_wr && rdy_wdata == '0)) |=> flag == $past(flag));
  // R6
  empty_pop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.pop && !evt.left_nz && !evt.push && !rdy_wr) |=> flag == $past(flag));
endmodule

// File: rtl/rx_ready_buffer.sv
module rx_ready_buffer
  import rx_buf_pkg::*;
#(
  parameter int unsigned DEPTH   = 6,
  parameter int unsigned WDATA_W = 32,
  localparam int unsigned PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_armed,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  input  logic               data_rd,
  input  logic               rdy_wr,
  input  logic [WDATA_W-1:0] rdy_wdata,
  output logic [7:0]         head_byte,
  output logic [CW-1:0]      free_slots,
  output logic               rdy_event
);
  logic [PW-1:0] head, wr_idx;
  logic [CW-1:0] count;
  logic          wr_en;
  evt_ctl_t      evt;

  rxb_ptr_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_armed (rx_armed),
    .in_valid (in_valid),
    .data_rd  (data_rd),
    .head     (head),
    .count    (count),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .evt      (evt)
  );

  rxb_store #(.DEPTH(DEPTH), .PW(PW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (in_byte),
    .rd_idx  (head),
    .rd_data (head_byte)
  );

  rxb_ready_flag #(.WDATA_W(WDATA_W)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .rdy_wr    (rdy_wr),
    .rdy_wdata (rdy_wdata),
    .flag      (rdy_event)
  );

  always_comb begin
    free_slots = rx_armed ? (CW'(DEPTH) - count) : '0;
  end

  // R3
  free_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_armed |-> free_slots == '0);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && free_slots != '0 && rdy_wr && rdy_wdata == '0) |=> rdy_event);
endmodule

// File: tb/rx_ready_buffer_bench.sv
module rx_ready_buffer_bench;
  localparam int DEPTH = 6;
  localparam int WW    = 32;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_armed = 1'b0, in_valid = 1'b0, data_rd = 1'b0, rdy_wr = 1'b0;
  logic [7:0]    in_byte = '0;
  logic [WW-1:0] rdy_wdata = '0;
  logic [7:0]    head_byte;
  logic [CW-1:0] free_slots;
  logic          rdy_event;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_mem [DEPTH];
  int         m_head, m_cnt;
  logic       m_flag;
  logic [7:0] seq = 8'h10;

  rx_ready_buffer #(.DEPTH(DEPTH), .WDATA_W(WW)) u_rx_ready_buffer (
    .clk(clk), .rst_n(rst_n), .rx_armed(rx_armed), .in_valid(in_valid),
    .in_byte(in_byte), .data_rd(data_rd), .rdy_wr(rdy_wr), .rdy_wdata(rdy_wdata),
    .head_byte(head_byte), .free_slots(free_slots), .rdy_event(rdy_event)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check combinational outputs, advance the model, check event
  task automatic step(input string tag, input logic a, input logic v, input logic [7:0] d,
                      input logic rd, input logic wr, input logic [WW-1:0] wd);
    logic pop, acc, set;
    @(negedge clk);
    rx_armed = a; in_valid = v; in_byte = d; data_rd = rd; rdy_wr = wr; rdy_wdata = wd;
    #1;
    chk({tag, " R1 head"}, int'(head_byte), int'(m_mem[m_head]));
    chk({tag, " R3 free"}, int'(free_slots), a ? DEPTH - m_cnt : 0);
    pop = rd && a && (m_cnt != 0);          // R2
    acc = v && (m_cnt < DEPTH);             // R5 discard when full
    if (acc) m_mem[(m_head + m_cnt) % DEPTH] = d;  // R4
    if (pop) m_head = (m_head + 1) % DEPTH;
    m_cnt = m_cnt + int'(acc) - int'(pop);  // R9
    set = acc || (pop && m_cnt != 0);       // R6
    if (set) m_flag = 1'b1;                 // R10 set wins
    else if (wr && wd == '0) m_flag = 1'b0; // R7
    @(posedge clk); #1;
    chk({tag, " R6/R7 event"}, int'(rdy_event), int'(m_flag));
  endtask

  task automatic drain();
    while (m_cnt != 0) step("drain R2", 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, '0);
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) begin
      seq = seq + 8'h07;
      step("fill R4", 1'b1, 1'b1, seq, 1'b0, 1'b0, '0);
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_head = 0; m_cnt = 0; m_flag = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; rx_armed = 1'b1; #1;
    // R8 reset state
    chk("R8 head", int'(head_byte), 0);
    chk("R8 free", int'(free_slots), DEPTH);
    chk("R8 event", int'(rdy_event), 0);

    // R5 overflow: fill, then push while full
    fill(DEPTH);
    chk("R5 full free", int'(free_slots), 0);
    step("R5 overflow", 1'b1, 1'b1, 8'hEE, 1'b0, 1'b1, '0);
    step("R5 after", 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, '0);
    // R7 nonzero write keeps, zero write clears
    step("R7 nonzero", 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 32'h8000_0000);
    step("R7 zero", 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, '0);
    // R2 disarmed read does nothing
    step("R2 disarmed", 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, '0);
    // R2 / R4 wrap and order: drain, refill so head wraps
    drain();
    step("R2 empty read", 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, '0);
    fill(4); drain(); fill(5);
    // R9 simultaneous arrival and pop
    step("R9 both", 1'b1, 1'b1, 8'hA5, 1'b1, 1'b0, '0);
    // R10 set beats zero write
    step("R10 clear", 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, '0);
    step("R10 set+clear", 1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, '0);
    drain();

    // Sweep: every fill level, all 32 input combinations
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      for (int c = 0; c < 32; c++) begin
        drain();
        step("sweep clr", 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, '0);
        fill(lvl);
        seq = seq + 8'h0B;
        step("sweep R1-mix", c[0], c[1], seq, c[2], c[3], c[4] ? 32'h0000_0100 : '0);
        step("sweep observe", 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, '0);
      end
    end

    // Pseudo-random run
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("random", lfsr[0] | lfsr[1], lfsr[2], lfsr[15:8], lfsr[3] & lfsr[4],
           lfsr[5] & lfsr[6], lfsr[7] ? 32'h1 : '0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule